// File: doc/BRIEF.md
# Per-thread commit squash controller

This block decides, for each hardware thread of an out-of-order core, when the commit stage flushes younger in-flight work. It drives the squash indications sent back to the front of the pipeline. Three sources can cause a flush:

- **Execute.** A squash request from execute is filtered against the youngest sequence number still considered valid for the thread. A request that is younger than a flush already applied cannot override it.
- **Trap.** A trap request places the thread in a waiting state and starts a programmable countdown. When the countdown expires, the whole thread is flushed.
- **Context squash.** An external context-squash request is latched and then flushes the whole thread.

A whole-thread flush takes its boundary from the reorder-buffer head. While the reorder buffer walks its entries, the block keeps signalling that a flush is in progress. When the buffer reports that the walk is done, the thread returns to normal running. The reorder-buffer walk itself and the generation of program counters are outside the block. The current committed PC arrives as an input.

Every output is registered. A request sampled at one clock edge appears on the outputs right after that edge. Each thread has its own independent copy of the control.

Top module: `commit_squash_ctrl`

## Requirements
- R1: After reset every thread reads status Idle (code 0) with squash, rob_squashing and the mispredict counter all zero, and a youngest tracked number of zero. Status codes are Idle=0, Running=1, RobSquashing=2, TrapPending=3 and FetchTrapPending=4; the last code is never entered by this block.
- R2: An execute squash is accepted when the thread is not TrapPending and the request number is at most the youngest tracked number. After the sampling edge, squash and rob_squashing are 1, status is 2, done_seq is the boundary, and the mispredict flag, taken flag and redirect PC are copied from the request.
- R3: An execute squash whose number is greater than the youngest tracked number leaves squash at 0 and leaves status unchanged.
- R4: With the include-self flag set, the boundary is the request number minus one, and the youngest tracked number becomes that boundary. A later request at boundary+1 is then rejected.
- R5: In status 2, rob_squashing is 1 after every edge at which the reorder buffer has not reported done. After the edge that samples done (with no new flush), status is 1 and rob_squashing is 0.
- R6: An insertion sets the youngest tracked number to the inserted number, except in a cycle that issues a flush.
- R7: A trap request is accepted when the thread is not TrapPending and no whole-thread flush is pending. After the accepting edge the status is 3. The whole-thread flush appears on the outputs L+1 edges after the accepting edge, where L is cfg_trap_lat and a value of 0 acts as 1. Execute squashes are rejected while the status is 3.
- R8: A whole-thread flush uses a boundary of head number minus one, or 0 when the reorder buffer is empty. It clears the mispredict and taken outputs, redirects to cur_pc, sets status 2 and resets the youngest tracked number to 0.
- R9: A context-squash request sampled at edge k is latched and produces the whole-thread flush on the outputs after edge k+1.
- R10: When a trap flush and a context flush are pending in the same cycle, the trap one is performed first and the context one in the following cycle, giving two consecutive squash pulses.
- R11: The per-thread mispredict counter increments by one for each accepted execute squash that has the mispredict flag set. It does not change for any other event.
- R12: Threads are independent: stimulus on one thread leaves the outputs of another thread unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trap_lat | input | LAT_W | Trap countdown length in cycles (0 acts as 1) |
| ex_sq_vld | input | NUM_THREADS | Execute squash request per thread |
| ex_sq_seq | input | NUM_THREADS*SEQ_W | Sequence number of the execute squash |
| ex_sq_self | input | NUM_THREADS | Include the squashing instruction itself |
| ex_sq_mispred | input | NUM_THREADS | Request stems from a branch mispredict |
| ex_sq_taken | input | NUM_THREADS | Branch taken flag of the request |
| ex_sq_pc | input | NUM_THREADS*PC_W | Redirect PC of the request |
| trap_req | input | NUM_THREADS | Start a delayed trap flush |
| ctx_sq_req | input | NUM_THREADS | External context-squash request |
| rob_sq_done | input | NUM_THREADS | Reorder buffer finished its flush walk |
| rob_head_seq | input | NUM_THREADS*SEQ_W | Sequence number at reorder-buffer head |
| rob_empty | input | NUM_THREADS | Reorder buffer holds nothing for the thread |
| ins_vld | input | NUM_THREADS | Instruction inserted this cycle |
| ins_seq | input | NUM_THREADS*SEQ_W | Sequence number of the inserted instruction |
| cur_pc | input | NUM_THREADS*PC_W | Current committed PC of the thread |
| squash_o | output | NUM_THREADS | Flush pulse to earlier stages |
| rob_squashing_o | output | NUM_THREADS | Reorder-buffer flush in progress |
| done_seq_o | output | NUM_THREADS*SEQ_W | Boundary of the latest flush |
| mispred_o | output | NUM_THREADS | Mispredict flag of the latest flush |
| taken_o | output | NUM_THREADS | Taken flag of the latest flush |
| redirect_pc_o | output | NUM_THREADS*PC_W | Redirect PC of the latest flush |
| status_o | output | NUM_THREADS*3 | Thread status code |
| mispred_cnt_o | output | NUM_THREADS*CNT_W | Accepted mispredict squash count |

## Verification
The assertions take the following for granted about the inputs:
- a trap request never arrives while that thread's countdown is still running;
- an include-self squash never carries sequence number zero, so the boundary cannot wrap.

The stimulus keeps within these limits as follows. Trap requests are issued only from the Running state, after the previous countdown has finished. Random execute squashes pick a number in a small window around the tracked youngest number, and they set include-self only for nonzero numbers. Random phases use only insertions, execute squashes and done indications, so the reference model never has to predict trap timing. Trap timing and flush ordering are covered by directed sequences.

// File: rtl/csq_pkg.sv
package csq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RUNNING    = 3'd1,
        ST_ROB_SQ     = 3'd2,
        ST_TRAP       = 3'd3,
        ST_FETCH_TRAP = 3'd4
    } csq_status_e;

    typedef struct packed {
        logic trap;
        logic ctx;
    } csq_pend_t;

    localparam int CSQ_SEQ_W = 16;
    localparam int CSQ_PC_W  = 32;
    localparam int CSQ_LAT_W = 6;
    localparam int CSQ_CNT_W = 16;
endpackage

// File: rtl/csq_trap_timer.sv
module csq_trap_timer #(
    parameter int LAT_W = csq_pkg::CSQ_LAT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LAT_W-1:0] lat,
    output logic             busy_o,
    output logic             expire_o
);
    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= (lat == '0) ? LAT_W'(1) : lat;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LAT_W'(1);
        end
    end

    assign busy_o   = (cnt_q != '0);
    assign expire_o = (cnt_q == LAT_W'(1));

    AST_TMR_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_o) else $error("timer restarted while busy"); // R7

    AST_TMR_EXPIRE_ENDS: assert property (@(posedge clk) disable iff (rst)
        (expire_o && !start) |=> !busy_o) else $error("timer kept running"); // R7
endmodule

// File: rtl/csq_thread.sv
module csq_thread
    import csq_pkg::*;
#(
    parameter int SEQ_W = CSQ_SEQ_W,
    parameter int PC_W  = CSQ_PC_W,
    parameter int LAT_W = CSQ_LAT_W,
    parameter int CNT_W = CSQ_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LAT_W-1:0] trap_lat,
    input  logic             ex_vld,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_self,
    input  logic             ex_mis,
    input  logic             ex_tkn,
    input  logic [PC_W-1:0]  ex_pc,
    input  logic             trap_req,
    input  logic             ctx_req,
    input  logic             rob_done,
    input  logic [SEQ_W-1:0] head_seq,
    input  logic             rob_empty,
    input  logic             ins_vld,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [PC_W-1:0]  cur_pc,
    output logic             sq_o,
    output logic             rsq_o,
    output logic [SEQ_W-1:0] done_o,
    output logic             mis_o,
    output logic             tkn_o,
    output logic [PC_W-1:0]  pc_o,
    output csq_status_e      st_o,
    output logic [CNT_W-1:0] cnt_o
);
    csq_status_e      st_q, st_n;
    csq_pend_t        pend_q, pend_n;
    logic [SEQ_W-1:0] young_q, young_n, done_q, done_n;
    logic [PC_W-1:0]  pc_q, pc_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             sq_q, sq_n, rsq_q, rsq_n, mis_q, mis_n, tkn_q, tkn_n;
    logic             trap_go, tmr_busy, tmr_expire;

    csq_trap_timer #(.LAT_W(LAT_W)) tmr_i (
        .clk      (clk),
        .rst      (rst),
        .start    (trap_go),
        .lat      (trap_lat),
        .busy_o   (tmr_busy),
        .expire_o (tmr_expire)
    );

    assign trap_go = trap_req && (st_q != ST_TRAP) && !pend_q.trap &&
                     !pend_q.ctx && !tmr_busy;

    always_comb begin
        logic             all_sq;
        logic [SEQ_W-1:0] bnd;
        st_n     = st_q;
        young_n  = young_q;
        done_n   = done_q;
        pc_n     = pc_q;
        cnt_n    = cnt_q;
        mis_n    = mis_q;
        tkn_n    = tkn_q;
        sq_n     = 1'b0;
        rsq_n    = 1'b0;
        pend_n.trap = pend_q.trap | tmr_expire;
        pend_n.ctx  = pend_q.ctx | ctx_req;
        all_sq   = 1'b0;
        bnd      = '0;

        if (st_q == ST_ROB_SQ) begin
            if (rob_done) st_n = ST_RUNNING;
            else          rsq_n = 1'b1;
        end

        if (trap_go) st_n = ST_TRAP;

        // whole-thread flush: trap has priority over context squash
        if (pend_q.trap) begin
            all_sq      = 1'b1;
            pend_n.trap = tmr_expire;
        end else if (pend_q.ctx) begin
            all_sq      = 1'b1;
            pend_n.ctx  = ctx_req;
        end

        if (all_sq) begin
            young_n = '0;
            done_n  = rob_empty ? '0 : head_seq - SEQ_W'(1);
            mis_n   = 1'b0;
            tkn_n   = 1'b0;
            pc_n    = cur_pc;
            sq_n    = 1'b1;
            rsq_n   = 1'b1;
            st_n    = ST_ROB_SQ;
        end

        if (ex_vld && (st_n != ST_TRAP) && (ex_seq <= young_n)) begin
            bnd     = ex_seq - SEQ_W'(ex_self);
            young_n = bnd;
            done_n  = bnd;
            mis_n   = ex_mis;
            tkn_n   = ex_tkn;
            pc_n    = ex_pc;
            sq_n    = 1'b1;
            rsq_n   = 1'b1;
            st_n    = ST_ROB_SQ;
            if (ex_mis) cnt_n = cnt_q + CNT_W'(1);
        end

        if (ins_vld && !sq_n) young_n = ins_seq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            pend_q  <= '0;
            young_q <= '0;
            done_q  <= '0;
            pc_q    <= '0;
            cnt_q   <= '0;
            sq_q    <= 1'b0;
            rsq_q   <= 1'b0;
            mis_q   <= 1'b0;
            tkn_q   <= 1'b0;
        end else begin
            st_q    <= st_n;
            pend_q  <= pend_n;
            young_q <= young_n;
            done_q  <= done_n;
            pc_q    <= pc_n;
            cnt_q   <= cnt_n;
            sq_q    <= sq_n;
            rsq_q   <= rsq_n;
            mis_q   <= mis_n;
            tkn_q   <= tkn_n;
        end
    end

    assign sq_o   = sq_q;
    assign rsq_o  = rsq_q;
    assign done_o = done_q;
    assign mis_o  = mis_q;
    assign tkn_o  = tkn_q;
    assign pc_o   = pc_q;
    assign st_o   = st_q;
    assign cnt_o  = cnt_q;

    AST_SQ_WITH_ROBSQ: assert property (@(posedge clk) disable iff (rst)
        sq_q |-> (rsq_q && st_q == ST_ROB_SQ)) else $error("squash without rob flush"); // R2

    AST_SQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(sq_q) |-> $past(ex_vld || pend_q.trap || pend_q.ctx)) else $error("uncaused squash"); // R3

    AST_TRAP_BLOCKS_EX: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TRAP && !pend_q.trap && !pend_q.ctx) |=> !sq_q) else $error("squash during trap wait"); // R7

    AST_DONE_TO_RUN: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ROB_SQ && rob_done && !ex_vld && !trap_req && !pend_q.trap && !pend_q.ctx)
        |=> (st_q == ST_RUNNING && !rsq_q)) else $error("did not leave flush"); // R5

    AST_ALL_CLEARS_MIS: assert property (@(posedge clk) disable iff (rst)
        ((pend_q.trap || pend_q.ctx) && !ex_vld) |=> (sq_q && !mis_q && !tkn_q)) else $error("bad full flush"); // R8

    AST_PRIO_CTX_WAITS: assert property (@(posedge clk) disable iff (rst)
        (pend_q.trap && pend_q.ctx) |=> pend_q.ctx) else $error("context flush not deferred"); // R10

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1))) else $error("counter jump"); // R11
endmodule

// File: rtl/commit_squash_ctrl.sv
module commit_squash_ctrl
    import csq_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int SEQ_W       = CSQ_SEQ_W,
    parameter int PC_W        = CSQ_PC_W,
    parameter int LAT_W       = CSQ_LAT_W,
    parameter int CNT_W       = CSQ_CNT_W
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [LAT_W-1:0]                    cfg_trap_lat,
    input  logic [NUM_THREADS-1:0]              ex_sq_vld,
    input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   ex_sq_seq,
    input  logic [NUM_THREADS-1:0]              ex_sq_self,
    input  logic [NUM_THREADS-1:0]              ex_sq_mispred,
    input  logic [NUM_THREADS-1:0]              ex_sq_taken,
    input  logic [NUM_THREADS-1:0][PC_W-1:0]    ex_sq_pc,
    input  logic [NUM_THREADS-1:0]              trap_req,
    input  logic [NUM_THREADS-1:0]              ctx_sq_req,
    input  logic [NUM_THREADS-1:0]              rob_sq_done,
    input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   rob_head_seq,
    input  logic [NUM_THREADS-1:0]              rob_empty,
    input  logic [NUM_THREADS-1:0]              ins_vld,
    input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   ins_seq,
    input  logic [NUM_THREADS-1:0][PC_W-1:0]    cur_pc,
    output logic [NUM_THREADS-1:0]              squash_o,
    output logic [NUM_THREADS-1:0]              rob_squashing_o,
    output logic [NUM_THREADS-1:0][SEQ_W-1:0]   done_seq_o,
    output logic [NUM_THREADS-1:0]              mispred_o,
    output logic [NUM_THREADS-1:0]              taken_o,
    output logic [NUM_THREADS-1:0][PC_W-1:0]    redirect_pc_o,
    output logic [NUM_THREADS-1:0][2:0]         status_o,
    output logic [NUM_THREADS-1:0][CNT_W-1:0]   mispred_cnt_o
);
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        csq_status_e st;

        csq_thread #(
            .SEQ_W (SEQ_W),
            .PC_W  (PC_W),
            .LAT_W (LAT_W),
            .CNT_W (CNT_W)
        ) thr_i (
            .clk       (clk),
            .rst       (rst),
            .trap_lat  (cfg_trap_lat),
            .ex_vld    (ex_sq_vld[t]),
            .ex_seq    (ex_sq_seq[t]),
            .ex_self   (ex_sq_self[t]),
            .ex_mis    (ex_sq_mispred[t]),
            .ex_tkn    (ex_sq_taken[t]),
            .ex_pc     (ex_sq_pc[t]),
            .trap_req  (trap_req[t]),
            .ctx_req   (ctx_sq_req[t]),
            .rob_done  (rob_sq_done[t]),
            .head_seq  (rob_head_seq[t]),
            .rob_empty (rob_empty[t]),
            .ins_vld   (ins_vld[t]),
            .ins_seq   (ins_seq[t]),
            .cur_pc    (cur_pc[t]),
            .sq_o      (squash_o[t]),
            .rsq_o     (rob_squashing_o[t]),
            .done_o    (done_seq_o[t]),
            .mis_o     (mispred_o[t]),
            .tkn_o     (taken_o[t]),
            .pc_o      (redirect_pc_o[t]),
            .st_o      (st),
            .cnt_o     (mispred_cnt_o[t])
        );

        assign status_o[t] = st;
    end
endmodule

// File: tb/commit_squash_ctrl_tb.sv
module commit_squash_ctrl_tb_top;
    localparam int T = 2, SW = 16, PW = 32, LW = 6, CW = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic [LW-1:0] cfg_trap_lat;
    logic [T-1:0] ex_sq_vld, ex_sq_self, ex_sq_mispred, ex_sq_taken;
    logic [T-1:0][SW-1:0] ex_sq_seq, rob_head_seq, ins_seq;
    logic [T-1:0][PW-1:0] ex_sq_pc, cur_pc;
    logic [T-1:0] trap_req, ctx_sq_req, rob_sq_done, rob_empty, ins_vld;
    logic [T-1:0] squash_o, rob_squashing_o, mispred_o, taken_o;
    logic [T-1:0][SW-1:0] done_seq_o;
    logic [T-1:0][PW-1:0] redirect_pc_o;
    logic [T-1:0][2:0] status_o;
    logic [T-1:0][CW-1:0] mispred_cnt_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    commit_squash_ctrl #(.NUM_THREADS(T), .SEQ_W(SW), .PC_W(PW), .LAT_W(LW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .cfg_trap_lat(cfg_trap_lat),
        .ex_sq_vld(ex_sq_vld), .ex_sq_seq(ex_sq_seq), .ex_sq_self(ex_sq_self),
        .ex_sq_mispred(ex_sq_mispred), .ex_sq_taken(ex_sq_taken), .ex_sq_pc(ex_sq_pc),
        .trap_req(trap_req), .ctx_sq_req(ctx_sq_req), .rob_sq_done(rob_sq_done),
        .rob_head_seq(rob_head_seq), .rob_empty(rob_empty), .ins_vld(ins_vld),
        .ins_seq(ins_seq), .cur_pc(cur_pc), .squash_o(squash_o),
        .rob_squashing_o(rob_squashing_o), .done_seq_o(done_seq_o), .mispred_o(mispred_o),
        .taken_o(taken_o), .redirect_pc_o(redirect_pc_o), .status_o(status_o),
        .mispred_cnt_o(mispred_cnt_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clr0();
        ex_sq_vld[0] = 0; ex_sq_self[0] = 0; ex_sq_mispred[0] = 0; ex_sq_taken[0] = 0;
        trap_req[0] = 0; ctx_sq_req[0] = 0; rob_sq_done[0] = 0; ins_vld[0] = 0;
    endtask

    task automatic ex0(input int seq, input bit self, input bit mis, input bit tkn, input int pc);
        ex_sq_vld[0] = 1; ex_sq_seq[0] = SW'(seq); ex_sq_self[0] = self;
        ex_sq_mispred[0] = mis; ex_sq_taken[0] = tkn; ex_sq_pc[0] = PW'(pc);
    endtask

    task automatic done0();
        clr0(); rob_sq_done[0] = 1; step(); clr0();
    endtask

    function automatic int exp_bnd(input int seq, input bit self);
        return self ? seq - 1 : seq;
    endfunction

    function automatic int exp_all_bnd(input bit empty, input int head);
        return empty ? 0 : head - 1;
    endfunction

    task automatic chk_t1_quiet(input string tag);
        chk({tag, " thread1 squash"}, squash_o[1], 0);
        chk({tag, " thread1 status"}, status_o[1], 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cfg_trap_lat = 3;
        ex_sq_vld = '0; ex_sq_seq = '0; ex_sq_self = '0; ex_sq_mispred = '0;
        ex_sq_taken = '0; ex_sq_pc = '0; trap_req = '0; ctx_sq_req = '0;
        rob_sq_done = '0; rob_head_seq = '0; rob_empty = '0; ins_vld = '0;
        ins_seq = '0; cur_pc = '0;
        rst = 1; step(); step(); rst = 0; step();

        // R1 reset state
        chk("R1 status", status_o[0], 0);
        chk("R1 squash", squash_o[0], 0);
        chk("R1 robsq", rob_squashing_o[0], 0);
        chk("R1 count", mispred_cnt_o[0], 0);
        chk_t1_quiet("R1");

        // R1 youngest=0: squash at 1 rejected
        ex0(1, 0, 0, 0, 0); step(); clr0();
        chk("R1 youngest zero", squash_o[0], 0);

        // R6 insert 10, R3 younger request rejected
        ins_vld[0] = 1; ins_seq[0] = 10; step(); clr0();
        ex0(12, 0, 1, 0, 0); step(); clr0();
        chk("R3 rejected squash", squash_o[0], 0);
        chk("R3 status kept", status_o[0], 0);
        chk("R3 count kept", mispred_cnt_o[0], 0);

        // R2 accepted
        ex0(8, 0, 1, 1, 'h100); step(); clr0();
        chk("R2 squash", squash_o[0], 1);
        chk("R2 robsq", rob_squashing_o[0], 1);
        chk("R2 status", status_o[0], 2);
        chk("R2 done", done_seq_o[0], exp_bnd(8, 0));
        chk("R2 mispred", mispred_o[0], 1);
        chk("R2 taken", taken_o[0], 1);
        chk("R2 pc", redirect_pc_o[0], 'h100);
        chk("R11 count inc", mispred_cnt_o[0], 1);
        chk_t1_quiet("R12");

        // R5 hold while not done, then return
        step();
        chk("R5 squash pulse", squash_o[0], 0);
        chk("R5 robsq held", rob_squashing_o[0], 1);
        chk("R5 status held", status_o[0], 2);
        done0();
        chk("R5 running", status_o[0], 1);
        chk("R5 robsq off", rob_squashing_o[0], 0);

        // R4 include-self
        ex0(6, 1, 0, 0, 'h104); step(); clr0();
        chk("R4 done", done_seq_o[0], exp_bnd(6, 1));
        chk("R11 no inc", mispred_cnt_o[0], 1);
        done0();
        ex0(6, 0, 0, 0, 0); step(); clr0();
        chk("R4 youngest boundary", squash_o[0], 0);

        // R6 insertion ignored in flush cycle
        ex0(5, 0, 0, 0, 0); ins_vld[0] = 1; ins_seq[0] = 20; step(); clr0();
        chk("R6 squash", squash_o[0], 1);
        done0();
        ex0(7, 0, 0, 0, 0); step(); clr0();
        chk("R6 insert dropped", squash_o[0], 0);
        ins_vld[0] = 1; ins_seq[0] = 30; step(); clr0();
        ex0(25, 0, 0, 0, 0); step(); clr0();
        chk("R6 insert taken", squash_o[0], 1);
        chk("R6 done", done_seq_o[0], 25);
        done0();

        // R7 trap countdown, R8 full flush
        trap_req[0] = 1; step(); clr0();
        chk("R7 trap pending", status_o[0], 3);
        ex0(20, 0, 1, 0, 0); step(); clr0();
        chk("R7 ex blocked", squash_o[0], 0);
        rob_head_seq[0] = 40; rob_empty[0] = 0; cur_pc[0] = 'h200;
        step();
        chk("R7 early 2", squash_o[0], 0);
        step();
        chk("R7 early 3", squash_o[0], 0);
        step();
        chk("R7 flush at L+1", squash_o[0], 1);
        chk("R8 done", done_seq_o[0], exp_all_bnd(0, 40));
        chk("R8 mispred", mispred_o[0], 0);
        chk("R8 taken", taken_o[0], 0);
        chk("R8 pc", redirect_pc_o[0], 'h200);
        chk("R8 status", status_o[0], 2);
        chk("R11 trap no inc", mispred_cnt_o[0], 1);
        done0();
        ex0(1, 0, 0, 0, 0); step(); clr0();
        chk("R8 youngest reset", squash_o[0], 0);
        ex0(0, 0, 0, 0, 0); step(); clr0();
        chk("R8 seq0 accepted", squash_o[0], 1);
        done0();

        // R9 context squash, empty ROB
        rob_empty[0] = 1; cur_pc[0] = 'h300;
        ctx_sq_req[0] = 1; step(); clr0();
        chk("R9 latched only", squash_o[0], 0);
        step();
        chk("R9 flush", squash_o[0], 1);
        chk("R8 empty boundary", done_seq_o[0], exp_all_bnd(1, 40));
        chk("R9 pc", redirect_pc_o[0], 'h300);
        done0();

        // R10 trap and context pending together
        rob_empty[0] = 0; rob_head_seq[0] = 45;
        trap_req[0] = 1; step(); clr0();
        step(); step();
        ctx_sq_req[0] = 1; step(); clr0();
        chk("R10 none yet", squash_o[0], 0);
        rob_head_seq[0] = 50; step();
        chk("R10 first pulse", squash_o[0], 1);
        chk("R10 first done", done_seq_o[0], 49);
        rob_head_seq[0] = 70; step();
        chk("R10 second pulse", squash_o[0], 1);
        chk("R10 second done", done_seq_o[0], 69);
        step();
        chk("R10 no third", squash_o[0], 0);
        done0();

        // R7 latency 0 acts as 1
        cfg_trap_lat = 0; rob_head_seq[0] = 12;
        trap_req[0] = 1; step(); clr0();
        chk("R7 lat0 pending", status_o[0], 3);
        step();
        chk("R7 lat0 wait", squash_o[0], 0);
        step();
        chk("R7 lat0 flush", squash_o[0], 1);
        chk("R7 lat0 done", done_seq_o[0], 11);
        done0();
        chk("R5 running before random", status_o[0], 1);

        // random phase: insertions, execute squashes, done indications
        begin
            int m_st, m_young, m_cnt, lo, seq;
            bit ev, es, em, ei, ed, acc, e_rsq;
            int e_st;
            void'($urandom(32'd1234));
            m_st = 1; m_young = 0; m_cnt = 1;
            for (int i = 0; i < 500; i++) begin
                ev = ($urandom % 10) < 3;
                ei = ($urandom % 2) == 1;
                ed = ($urandom % 10) < 4;
                em = ($urandom % 2) == 1;
                lo = (m_young > 5) ? m_young - 5 : 0;
                seq = lo + int'($urandom % 9);
                es = (seq > 0) ? (($urandom % 2) == 1) : 1'b0;
                clr0();
                if (ev) ex0(seq, es, em, 0, i);
                ins_vld[0] = ei; ins_seq[0] = SW'(m_young + 1 + int'($urandom % 4));
                rob_sq_done[0] = ed;
                // model
                e_st = m_st; e_rsq = 0;
                if (m_st == 2) begin
                    if (ed) e_st = 1; else e_rsq = 1;
                end
                acc = ev && (seq <= m_young);
                if (acc) begin
                    m_young = exp_bnd(seq, es);
                    e_rsq = 1; e_st = 2;
                    if (em) m_cnt++;
                end else if (ei) begin
                    m_young = int'(ins_seq[0]);
                end
                m_st = e_st;
                step();
                chk("R2 random squash", squash_o[0], acc);
                chk("R5 random robsq", rob_squashing_o[0], e_rsq);
                chk("R5 random status", status_o[0], e_st);
                chk("R11 random count", mispred_cnt_o[0], m_cnt);
                if (acc) chk("R4 random done", done_seq_o[0], m_young);
                if (i % 50 == 0) chk_t1_quiet("R12 random");
            end
            clr0();
        end
        chk_t1_quiet("R12 end");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule